// File: doc/BRIEF.md
# Oscillator Warm-up Timer and System Clock Switch

This block times the settling period of an oscillator. When that period has ended, it moves the system clock from one oscillator to the other without producing a short pulse. Software writes a 14-bit settling count into two fields: twelve upper bits and two lower bits. The count is in units of 16 oscillator cycles, because the four low bits of the wanted cycle count are dropped. Software then picks which oscillator clocks the timer, sets a start bit and polls a busy flag until it clears.

After that, software changes the system-clock select bit and polls a read-only flag. This flag reports that the slow oscillator really is driving the system clock. Each oscillator has its own enable bit, and the enable gates that oscillator's clock input. The fast oscillator may be switched off once the slow one has taken over.

The clock mux synchronises the select into each oscillator domain. It drops the old clock's gate before it raises the new one. The completion flag is taken from the new gate through a two-flop synchroniser. The busy flag also reaches the bus clock through a two-flop synchroniser.

Top module: `clkgen_warmup`

## Requirements
- R1: After reset, the control register (address 0) reads 0x0001. The fast oscillator is enabled (bit0=1) and all other bits are 0: slow enable, timer clock select, busy, system select and the active-slow flag. The system clock runs at the fast oscillator rate.
- R2: The upper count field is at address 1 and keeps 12 bits. The lower count field is at address 2 and keeps 2 bits. Each field reads back what was written, masked to its width, and the unused bits read 0.
- R3: After a start, busy (control bit3) stays 1 for at least N*16 and at most N*16+5 rising edges of the timer's oscillator. N is {upper,lower}, the upper field forming the high bits.
- R4: Control bit2 selects the timer clock. A value of 0 counts the fast oscillator and 1 counts the slow oscillator.
- R5: Writing control bit3=1 while busy is 0 starts the timer. Busy reads 1 in the bus cycle after the write.
- R6: Writing either count field while busy is 1 leaves the duration of the run in progress unchanged.
- R7: Writing control bit3=1 while busy is 1 is ignored. The run in progress is not restarted or extended.
- R8: Control bit4 selects the system clock, 0 for fast and 1 for slow. Control bit5 reads 0 in the cycle after bit4 is set. It reads 1 only once the system clock runs at the slow rate. It returns to 0 after switching back to fast.
- R9: During every clock switch, the system clock shows no high or low phase shorter than half the fast oscillator period.
- R10: Control bit0 (fast enable) and bit1 (slow enable) gate their oscillators. Clearing bit0 while the slow clock is active leaves the system clock running at the slow rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register and status clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data (combinational) |
| fast_osc | input | 1 | Fast oscillator clock |
| slow_osc | input | 1 | Slow oscillator clock |
| sys_clk | output | 1 | Selected, gated system clock |

## Verification
The bench measures the busy period in edges of the chosen oscillator, with both timer clock selects. A timer that ignored the four dropped bits, or counted the wrong clock, would end the period far too early or too late. It rewrites the count fields and the start bit in the middle of a run. A design that reloaded or restarted would stretch the busy period well past N*16 edges. Across each clock switch, the bench watches every system clock phase width and counts edges over a fixed window. It polls the completion flag right after the select changes. An unsafe mux would show a short pulse, and an early flag would read 1 before the slow clock is running.

// File: rtl/clkgen_warmup.sv
module clkgen_warmup #(
  parameter int HI_W  = 12,
  parameter int LO_W  = 2,
  parameter int UNIT  = 4,
  parameter int BUS_W = 16
) (
  input  logic             clk_bus,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  input  logic             fast_osc,
  input  logic             slow_osc,
  output logic             sys_clk
);
  localparam int NW = HI_W + LO_W;
  localparam int CW = NW + UNIT;

  logic            fast_on, slow_on, tsel, ssel, req_tog;
  logic [HI_W-1:0] cnt_hi, load_hi;
  logic [LO_W-1:0] cnt_lo, load_lo;
  logic            ack_s1, ack_s2, act_s1, act_s2;
  logic            busy, start;

  // oscillator gating and timer clock
  wire fast_g = fast_osc & fast_on;
  wire slow_g = slow_osc & slow_on;
  wire tmr_clk = tsel ? slow_g : fast_g;

  assign start = wr_en && wr_addr == 2'd0 && wr_data[3] && !busy;

  always_ff @(posedge clk_bus or negedge rst_n)
    if (!rst_n) begin
      fast_on <= 1'b1; slow_on <= 1'b0; tsel <= 1'b0; ssel <= 1'b0;
      cnt_hi <= '0; cnt_lo <= '0; load_hi <= '0; load_lo <= '0; req_tog <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 2'd0) begin
        fast_on <= wr_data[0];
        slow_on <= wr_data[1];
        if (!busy) tsel <= wr_data[2];
        ssel    <= wr_data[4];
      end
      if (wr_en && wr_addr == 2'd1) cnt_hi <= wr_data[HI_W-1:0];
      if (wr_en && wr_addr == 2'd2) cnt_lo <= wr_data[LO_W-1:0];
      if (start) begin
        load_hi <= cnt_hi;
        load_lo <= cnt_lo;
        req_tog <= ~req_tog;
      end
    end

  // warm-up counter in the selected oscillator domain
  logic          req_s1, req_s2, ack_tog;
  logic [CW-1:0] cnt;
  wire  [CW-1:0] total = {load_hi, load_lo, {UNIT{1'b0}}};
  wire  [CW:0]   cnt_nx = {1'b0, cnt} + 1'b1;
  wire           run = req_s2 ^ ack_tog;

  always_ff @(posedge tmr_clk or negedge rst_n)
    if (!rst_n) begin
      req_s1 <= 1'b0; req_s2 <= 1'b0; ack_tog <= 1'b0; cnt <= '0;
    end else begin
      req_s1 <= req_tog;
      req_s2 <= req_s1;
      if (!run) cnt <= '0;
      else if (cnt_nx >= {1'b0, total}) begin
        cnt <= '0;
        ack_tog <= req_s2;
      end else cnt <= cnt_nx[CW-1:0];
    end

  // glitch-free clock mux: gates change on each clock's falling edge
  logic f1, f2, s1, s2;
  always_ff @(negedge fast_g or negedge rst_n)
    if (!rst_n) begin f1 <= 1'b1; f2 <= 1'b1; end
    else begin f1 <= ~ssel & ~s2; f2 <= f1; end

  always_ff @(negedge slow_g or negedge rst_n)
    if (!rst_n) begin s1 <= 1'b0; s2 <= 1'b0; end
    else begin s1 <= ssel & ~f2; s2 <= s1; end

  assign sys_clk = (fast_g & f2) | (slow_g & s2);

  // status synchronisers into the bus domain
  always_ff @(posedge clk_bus or negedge rst_n)
    if (!rst_n) begin
      ack_s1 <= 1'b0; ack_s2 <= 1'b0; act_s1 <= 1'b0; act_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_tog; ack_s2 <= ack_s1;
      act_s1 <= s2;      act_s2 <= act_s1;
    end

  assign busy = req_tog ^ ack_s2;

  always_comb
    case (rd_addr)
      2'd0:    rd_data = BUS_W'({act_s2, ssel, busy, tsel, slow_on, fast_on});
      2'd1:    rd_data = BUS_W'(cnt_hi);
      2'd2:    rd_data = BUS_W'(cnt_lo);
      default: rd_data = '0;
    endcase

  p_start_busy_r5: assert property (@(posedge clk_bus) disable iff (!rst_n)
    start |=> busy);
  p_load_frozen_r6: assert property (@(posedge clk_bus) disable iff (!rst_n)
    ($past(busy) && busy) |-> ($stable(load_hi) && $stable(load_lo)));
  p_no_restart_r7: assert property (@(posedge clk_bus) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(req_tog));
  p_flag_needs_sel_r8: assert property (@(posedge clk_bus) disable iff (!rst_n)
    $rose(act_s2) |-> ssel);
  p_no_overlap_r9: assert property (@(posedge clk_bus) disable iff (!rst_n)
    !(f2 && s2));
endmodule

// File: tb/clkgen_warmup_test.sv
`timescale 1ns/1ps
module clkgen_warmup_test;
  logic clk_bus = 0, rst_n = 0, wr_en = 0, fast_osc = 0, slow_osc = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic sys_clk;
  int checks = 0, fails = 0;
  int fast_edges = 0, slow_edges = 0, sys_edges = 0, glitches = 0;
  bit mon_on = 0;
  realtime last_t = 0;
  logic [15:0] ctrl = 16'h0001;

  clkgen_warmup uut (.*);

  always #4  clk_bus  = ~clk_bus;
  always #5  fast_osc = ~fast_osc;
  always #15 slow_osc = ~slow_osc;
  always @(posedge fast_osc) fast_edges++;
  always @(posedge slow_osc) slow_edges++;
  always @(posedge sys_clk) sys_edges++;
  always @(sys_clk) begin
    if (mon_on && ($realtime - last_t) < 4.5) glitches++;
    last_t = $realtime;
  end

  task automatic chk(string req, int act, int exp_lo, int exp_hi);
    checks++;
    if (act < exp_lo || act > exp_hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_bus); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk_bus); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rate(output int n);
    int s = sys_edges;
    #600;
    n = sys_edges - s;
  endtask

  // starts a run, optionally disturbs it, returns oscillator edges while busy
  task automatic warm(input logic [11:0] hi, input logic [1:0] lo, input bit use_slow,
                      input int disturb, output int edges);
    logic [15:0] d;
    int s, k;
    wr(2'd1, {4'h0, hi});
    wr(2'd2, {14'h0, lo});
    ctrl[2] = use_slow;
    wr(2'd0, ctrl);
    s = use_slow ? slow_edges : fast_edges;
    wr(2'd0, ctrl | 16'h0008);
    rd(2'd0, d);
    chk("R5 busy after start", int'(d[3]), 1, 1);
    k = 0;
    while (d[3] && k < 20000) begin
      @(negedge clk_bus); k++;
      if (k == 30 && disturb == 1) begin wr(2'd1, 16'h0FFF); wr(2'd2, 16'h0003); end
      if (k == 30 && disturb == 2) wr(2'd0, ctrl | 16'h0008);
      rd(2'd0, d);
    end
    edges = (use_slow ? slow_edges : fast_edges) - s;
  endtask

  task automatic t_reset;
    logic [15:0] d; int n;
    rd(2'd0, d);
    chk("R1 ctrl reset", int'(d), 1, 1);
    rate(n);
    chk("R1 fast rate after reset", n, 55, 62);
  endtask

  task automatic t_fields;
    logic [15:0] d;
    wr(2'd1, 16'h0200); rd(2'd1, d); chk("R2 upper 0x200", int'(d), 'h200, 'h200);
    wr(2'd1, 16'hFFFF); rd(2'd1, d); chk("R2 upper mask", int'(d), 'hFFF, 'hFFF);
    wr(2'd2, 16'hFFFF); rd(2'd2, d); chk("R2 lower mask", int'(d), 3, 3);
    wr(2'd2, 16'h0001); rd(2'd2, d); chk("R2 lower 1", int'(d), 1, 1);
  endtask

  task automatic t_warm;
    int e;
    warm(12'h000, 2'd2, 1'b0, 0, e); chk("R3 R4 fast N=2", e, 32, 37);
    warm(12'h001, 2'd1, 1'b0, 0, e); chk("R3 R4 fast N=5", e, 80, 85);
    ctrl[1] = 1; wr(2'd0, ctrl);
    warm(12'h000, 2'd3, 1'b1, 0, e); chk("R3 R4 slow N=3", e, 48, 53);
    warm(12'h000, 2'd0, 1'b1, 0, e); chk("R3 N=0", e, 0, 5);
  endtask

  task automatic t_ignore;
    int e;
    warm(12'h000, 2'd2, 1'b1, 1, e); chk("R6 field write while busy", e, 32, 37);
    warm(12'h000, 2'd2, 1'b0, 2, e); chk("R7 restart while busy", e, 32, 37);
  endtask

  task automatic t_switch;
    logic [15:0] d; int n, k;
    mon_on = 1;
    ctrl[1] = 1; ctrl[2] = 0; ctrl[4] = 1; wr(2'd0, ctrl);
    rd(2'd0, d); chk("R8 flag not early", int'(d[5]), 0, 0);
    k = 0;
    while (!d[5] && k < 500) begin @(negedge clk_bus); k++; rd(2'd0, d); end
    chk("R8 flag set", int'(d[5]), 1, 1);
    rate(n); chk("R8 slow rate", n, 18, 22);
    ctrl[0] = 0; wr(2'd0, ctrl);
    rate(n); chk("R10 slow with fast off", n, 18, 22);
    ctrl[0] = 1; ctrl[4] = 0; wr(2'd0, ctrl);
    k = 0; rd(2'd0, d);
    while (d[5] && k < 500) begin @(negedge clk_bus); k++; rd(2'd0, d); end
    chk("R8 flag clears", int'(d[5]), 0, 0);
    #100;
    rate(n); chk("R8 fast rate back", n, 55, 62);
    chk("R9 no short pulses", glitches, 0, 0);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #33 rst_n = 1;
    repeat (3) @(negedge clk_bus);
    t_reset;
    t_fields;
    t_warm;
    t_ignore;
    t_switch;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule